// File: doc/BRIEF.md
# Tagged ALU type-rule checker

This block decides in hardware whether a tagged add, subtract or multiply may take its fast path. Each operand arrives with an 8-bit type tag. The block looks up the opcode and both source tags in a small associative rule table, which is loaded before any tagged work begins. On a hit it supplies the destination's type tag and its integer/floating-point flag. The flag lets decode choose the integer or the FP datapath. It also raises the write enables for the destination's value and tag.

On a miss it flags a type misprediction, holds back both write enables and redirects the next PC to a programmable handler address. That address lives in a register that a dedicated instruction writes. A check-only mode performs the same lookup but never asks for a register write. It still redirects when the lookup misses.

Top module: `tag_rule_check`

## Requirements
- R1: After reset every rule entry is invalid, so any lookup misses, and the handler address is 0.
- R2: A load with `ld_en_i` high stores the opcode, both source tags, the result tag and the result FP flag into entry `ld_idx_i`. The entry is valid for lookups from the next clock cycle on. A lookup in the same cycle as the load still sees the old contents.
- R3: A valid lookup hits only when one valid entry matches the opcode, tag A and tag B exactly, with the operand order kept. On a hit, `hit_o`, `dst_tag_o` and `dst_fp_o` give that entry's result within the same cycle. The opcode encoding is add=0, subtract=1, multiply=2.
- R4: When several valid entries match the same key, the entry with the lowest index supplies the result.
- R5: On a miss, `miss_o` and `redirect_o` are high, `redirect_pc_o` equals the handler register, and `val_we_o` and `tag_we_o` are low.
- R6: A handler write with `hdl_we_i` high sets the redirect address used from the next cycle on.
- R7: A check-only lookup that hits raises `hit_o` with no write enable and no redirect. A check-only lookup that misses redirects exactly as in R5.
- R8: With `req_valid_i` low, `hit_o`, `miss_o`, `redirect_o`, `val_we_o` and `tag_we_o` are low. `dst_tag_o`, `dst_fp_o` and `redirect_pc_o` are 0.
- R9: Reloading an entry replaces its old key, so the old key no longer matches that entry.
- R10: `hit_o` and `miss_o` are never high together, and `redirect_o` is never high together with either write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Load one rule entry |
| ld_idx_i | input | IDX_W (4) | Entry index to load |
| ld_op_i | input | 2 | Opcode key of the loaded rule |
| ld_tag_a_i | input | 8 | Source tag A key |
| ld_tag_b_i | input | 8 | Source tag B key |
| ld_res_tag_i | input | 8 | Result tag of the rule |
| ld_res_fp_i | input | 1 | Result FP flag (1 = floating point) |
| hdl_we_i | input | 1 | Write the handler register |
| hdl_addr_i | input | PC_W (32) | New handler address |
| req_valid_i | input | 1 | A tagged operation is presented |
| req_chk_only_i | input | 1 | Check-only mode, no value is produced |
| req_op_i | input | 2 | Opcode of the tagged operation |
| req_tag_a_i | input | 8 | Type tag of source A |
| req_tag_b_i | input | 8 | Type tag of source B |
| hit_o | output | 1 | Lookup hit |
| miss_o | output | 1 | Type misprediction |
| dst_tag_o | output | 8 | Destination type tag |
| dst_fp_o | output | 1 | Destination FP flag, selects the datapath |
| val_we_o | output | 1 | Destination value write enable |
| tag_we_o | output | 1 | Destination tag write enable |
| redirect_o | output | 1 | Redirect the next PC |
| redirect_pc_o | output | PC_W (32) | Redirect target |

## Verification
Every lookup result is combinational. Hit, miss, destination tag and flag, write enables and redirect therefore belong to the same cycle as the request. Rule loads and handler writes take effect at the next rising edge and show up in the cycle after. The bench changes inputs on the falling edge and samples 5 ns later, before the next rising edge. For a load or handler write it samples only after the edge that commits it, and once also in the same cycle to confirm that the old contents are still used.

// File: rtl/tag_rule_pkg.sv
package tag_rule_pkg;
  localparam int TAG_W = 8;
  localparam int OP_W  = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_RSV = 2'd3
  } top_e;

  typedef struct packed {
    logic             valid;
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] tag_a;
    logic [TAG_W-1:0] tag_b;
    logic [TAG_W-1:0] res_tag;
    logic             res_fp;
  } rule_t;
endpackage

// File: rtl/trc_table.sv
module trc_table import tag_rule_pkg::*; #(
  parameter int NUM_RULES = 16,
  localparam int IDX_W = $clog2(NUM_RULES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ld_en_i,
  input  logic [IDX_W-1:0]           ld_idx_i,
  input  logic [OP_W-1:0]            ld_op_i,
  input  logic [TAG_W-1:0]           ld_tag_a_i,
  input  logic [TAG_W-1:0]           ld_tag_b_i,
  input  logic [TAG_W-1:0]           ld_res_tag_i,
  input  logic                       ld_res_fp_i,
  output rule_t [NUM_RULES-1:0]      rules_o
);
  rule_t ld_rule;

  always_comb begin
    ld_rule.valid   = 1'b1;
    ld_rule.op      = ld_op_i;
    ld_rule.tag_a   = ld_tag_a_i;
    ld_rule.tag_b   = ld_tag_b_i;
    ld_rule.res_tag = ld_res_tag_i;
    ld_rule.res_fp  = ld_res_fp_i;
  end

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_entry
    logic we;
    assign we = ld_en_i && (ld_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rules_o[i] <= '0;
      end else if (we) begin
        rules_o[i] <= ld_rule;
      end
    end
  end
endmodule

// File: rtl/trc_match.sv
module trc_match import tag_rule_pkg::*; #(
  parameter int NUM_RULES = 16
) (
  input  rule_t [NUM_RULES-1:0] rules_i,
  input  logic [OP_W-1:0]       op_i,
  input  logic [TAG_W-1:0]      tag_a_i,
  input  logic [TAG_W-1:0]      tag_b_i,
  output logic                  hit_o,
  output logic [TAG_W-1:0]      res_tag_o,
  output logic                  res_fp_o
);
  logic [NUM_RULES-1:0] match;

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_cmp
    assign match[i] = rules_i[i].valid &&
                      (rules_i[i].op    == op_i)    &&
                      (rules_i[i].tag_a == tag_a_i) &&
                      (rules_i[i].tag_b == tag_b_i);
  end

  // walk downward so the lowest matching index is the last one written
  always_comb begin
    res_tag_o = '0;
    res_fp_o  = 1'b0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (match[i]) begin
        res_tag_o = rules_i[i].res_tag;
        res_fp_o  = rules_i[i].res_fp;
      end
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/trc_handler.sv
module trc_handler #(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PC_W-1:0] addr_i,
  output logic [PC_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
    end else if (we_i) begin
      addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/tag_rule_check.sv
module tag_rule_check import tag_rule_pkg::*; #(
  parameter int NUM_RULES = 16,
  parameter int PC_W      = 32,
  localparam int IDX_W    = $clog2(NUM_RULES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [1:0]       ld_op_i,
  input  logic [7:0]       ld_tag_a_i,
  input  logic [7:0]       ld_tag_b_i,
  input  logic [7:0]       ld_res_tag_i,
  input  logic             ld_res_fp_i,
  input  logic             hdl_we_i,
  input  logic [PC_W-1:0]  hdl_addr_i,
  input  logic             req_valid_i,
  input  logic             req_chk_only_i,
  input  logic [1:0]       req_op_i,
  input  logic [7:0]       req_tag_a_i,
  input  logic [7:0]       req_tag_b_i,
  output logic             hit_o,
  output logic             miss_o,
  output logic [7:0]       dst_tag_o,
  output logic             dst_fp_o,
  output logic             val_we_o,
  output logic             tag_we_o,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o
);
  rule_t [NUM_RULES-1:0] rules;
  logic                  lk_hit;
  logic [TAG_W-1:0]      lk_tag;
  logic                  lk_fp;
  logic [PC_W-1:0]       hdl_addr;
  logic                  do_write;

  trc_table #(.NUM_RULES(NUM_RULES)) i_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ld_en_i      (ld_en_i),
    .ld_idx_i     (ld_idx_i),
    .ld_op_i      (ld_op_i),
    .ld_tag_a_i   (ld_tag_a_i),
    .ld_tag_b_i   (ld_tag_b_i),
    .ld_res_tag_i (ld_res_tag_i),
    .ld_res_fp_i  (ld_res_fp_i),
    .rules_o      (rules)
  );

  trc_match #(.NUM_RULES(NUM_RULES)) i_match (
    .rules_i   (rules),
    .op_i      (req_op_i),
    .tag_a_i   (req_tag_a_i),
    .tag_b_i   (req_tag_b_i),
    .hit_o     (lk_hit),
    .res_tag_o (lk_tag),
    .res_fp_o  (lk_fp)
  );

  trc_handler #(.PC_W(PC_W)) i_handler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (hdl_we_i),
    .addr_i (hdl_addr_i),
    .addr_o (hdl_addr)
  );

  assign hit_o         = req_valid_i && lk_hit;
  assign miss_o        = req_valid_i && !lk_hit;
  assign dst_tag_o     = hit_o ? lk_tag : '0;
  assign dst_fp_o      = hit_o && lk_fp;
  assign do_write      = hit_o && !req_chk_only_i;
  assign val_we_o      = do_write;
  assign tag_we_o      = do_write;
  assign redirect_o    = miss_o;
  assign redirect_pc_o = miss_o ? hdl_addr : '0;
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_chk_only_i,
  input logic            hdl_we_i,
  input logic [PC_W-1:0] hdl_addr_i,
  input logic            hit_o,
  input logic            miss_o,
  input logic            val_we_o,
  input logic            tag_we_o,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o
);
  assert_hit_miss_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o) && !(redirect_o && (val_we_o || tag_we_o)));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !hit_o && !miss_o && !redirect_o && !val_we_o && !tag_we_o);

  assert_miss_redirect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> redirect_o && !val_we_o && !tag_we_o);

  assert_chk_nowrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_chk_only_i |-> !val_we_o && !tag_we_o);

  assert_handler_next_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hdl_we_i) && redirect_o) |-> (redirect_pc_o == $past(hdl_addr_i)));
endmodule

bind tag_rule_check trc_checker #(.PC_W(PC_W)) i_trc_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_chk_only_i (req_chk_only_i),
  .hdl_we_i       (hdl_we_i),
  .hdl_addr_i     (hdl_addr_i),
  .hit_o          (hit_o),
  .miss_o         (miss_o),
  .val_we_o       (val_we_o),
  .tag_we_o       (tag_we_o),
  .redirect_o     (redirect_o),
  .redirect_pc_o  (redirect_pc_o)
);

// File: tb/test_tag_rule_check.sv
`timescale 1ns/1ps
module test_tag_rule_check;
  localparam int PC_W = 32;
  localparam logic [PC_W-1:0] HDL_A = 32'h8000_1000;
  localparam logic [PC_W-1:0] HDL_B = 32'h0000_2F40;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ld_en_i = 1'b0;
  logic [3:0] ld_idx_i = '0;
  logic [1:0] ld_op_i = '0;
  logic [7:0] ld_tag_a_i = '0, ld_tag_b_i = '0, ld_res_tag_i = '0;
  logic ld_res_fp_i = 1'b0;
  logic hdl_we_i = 1'b0;
  logic [PC_W-1:0] hdl_addr_i = '0;
  logic req_valid_i = 1'b0, req_chk_only_i = 1'b0;
  logic [1:0] req_op_i = '0;
  logic [7:0] req_tag_a_i = '0, req_tag_b_i = '0;
  logic hit_o, miss_o, dst_fp_o, val_we_o, tag_we_o, redirect_o;
  logic [7:0] dst_tag_o;
  logic [PC_W-1:0] redirect_pc_o;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  tag_rule_check i_tag_rule_check (.*);

  typedef struct packed {
    logic [1:0] op;
    logic       chk;
    logic [7:0] a;
    logic [7:0] b;
    logic       hit;
    logic [7:0] tag;
    logic       fp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 8'h01, 8'h01, 1'b1, 8'h01, 1'b0},
    '{2'd0, 1'b0, 8'h02, 8'h02, 1'b1, 8'h02, 1'b1},
    '{2'd0, 1'b0, 8'h01, 8'h02, 1'b1, 8'h02, 1'b1},
    '{2'd0, 1'b0, 8'h02, 8'h01, 1'b0, 8'h00, 1'b0},
    '{2'd1, 1'b0, 8'h01, 8'h01, 1'b0, 8'h00, 1'b0},
    '{2'd2, 1'b0, 8'h01, 8'h01, 1'b1, 8'h01, 1'b0},
    '{2'd1, 1'b0, 8'h03, 8'h04, 1'b1, 8'h33, 1'b0},
    '{2'd2, 1'b0, 8'hFF, 8'hFF, 1'b1, 8'hAB, 1'b1},
    '{2'd0, 1'b1, 8'h01, 8'h01, 1'b1, 8'h01, 1'b0},
    '{2'd1, 1'b1, 8'h09, 8'h09, 1'b0, 8'h00, 1'b0}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(int idx, int op, int a, int b, int rt, bit fp);
    ld_en_i = 1'b1; ld_idx_i = 4'(idx); ld_op_i = 2'(op);
    ld_tag_a_i = 8'(a); ld_tag_b_i = 8'(b); ld_res_tag_i = 8'(rt); ld_res_fp_i = fp;
    @(negedge clk_i);
    ld_en_i = 1'b0;
  endtask

  task automatic set_hdl(logic [PC_W-1:0] a);
    hdl_we_i = 1'b1; hdl_addr_i = a;
    @(negedge clk_i);
    hdl_we_i = 1'b0;
  endtask

  task automatic req(int op, bit chk, int a, int b);
    req_valid_i = 1'b1; req_chk_only_i = chk; req_op_i = 2'(op);
    req_tag_a_i = 8'(a); req_tag_b_i = 8'(b);
    #5;
  endtask

  // full comparison of one lookup against expected hit/tag/fp
  task automatic expect_lookup(string r, bit chk, bit hit, int tag, bit fp, logic [PC_W-1:0] hdl);
    check(r, {hit_o, miss_o}, {hit, !hit});
    check(r, {dst_tag_o, dst_fp_o}, {8'(hit ? tag : 0), hit && fp});
    check(r, {val_we_o, tag_we_o}, {hit && !chk, hit && !chk});
    check(r, {redirect_o, redirect_pc_o}, {!hit, hit ? '0 : hdl});
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: empty table, handler 0
    req(0, 0, 0, 0);
    expect_lookup("R1", 0, 0, 0, 0, '0);
    // R8: idle
    req_valid_i = 1'b0; #1;
    check("R8", {hit_o, miss_o, redirect_o, val_we_o, tag_we_o, dst_tag_o, dst_fp_o, redirect_pc_o}, '0);
    @(negedge clk_i);

    // preload
    load(0, 0, 1, 1, 8'h01, 0);
    load(1, 0, 2, 2, 8'h02, 1);
    load(2, 0, 1, 2, 8'h02, 1);
    load(3, 2, 1, 1, 8'h01, 0);
    load(4, 0, 1, 1, 8'h09, 1);
    load(5, 1, 3, 4, 8'h33, 0);
    load(15, 2, 8'hFF, 8'hFF, 8'hAB, 1);
    set_hdl(HDL_A);

    // R3 R4 R5 R7 vectors
    for (int i = 0; i < NV; i++) begin
      req(VECS[i].op, VECS[i].chk, VECS[i].a, VECS[i].b);
      expect_lookup(VECS[i].chk ? "R7" : (VECS[i].hit ? "R3/R4" : "R5"),
                    VECS[i].chk, VECS[i].hit, VECS[i].tag, VECS[i].fp, HDL_A);
      @(negedge clk_i);
    end

    // R6: handler write applies from next cycle, same-cycle uses old
    req(0, 0, 2, 1);
    hdl_we_i = 1'b1; hdl_addr_i = HDL_B; #1;
    check("R6", redirect_pc_o, HDL_A);
    @(negedge clk_i);
    hdl_we_i = 1'b0; #5;
    check("R6", {redirect_o, redirect_pc_o}, {1'b1, HDL_B});
    @(negedge clk_i);

    // R2: load into a new slot, same-cycle lookup sees old contents
    req(1, 0, 8'h10, 8'h20);
    ld_en_i = 1'b1; ld_idx_i = 4'd7; ld_op_i = 2'd1; ld_tag_a_i = 8'h10;
    ld_tag_b_i = 8'h20; ld_res_tag_i = 8'h5C; ld_res_fp_i = 1'b1; #1;
    check("R2", hit_o, 1'b0);
    @(negedge clk_i);
    ld_en_i = 1'b0; #5;
    expect_lookup("R2", 0, 1, 8'h5C, 1, HDL_B);
    @(negedge clk_i);

    // R9: overwrite entry 0, old key falls to entry 4 (R4 order)
    load(0, 1, 7, 7, 8'h77, 0);
    req(0, 0, 1, 1);
    expect_lookup("R9", 0, 1, 8'h09, 1, HDL_B);
    @(negedge clk_i);
    req(1, 0, 7, 7);
    expect_lookup("R9", 0, 1, 8'h77, 0, HDL_B);
    @(negedge clk_i);

    // R1: reset mid-run clears rules and handler
    req_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    req(2, 0, 8'hFF, 8'hFF);
    expect_lookup("R1", 0, 0, 0, 0, '0);
    @(negedge clk_i);
    req_valid_i = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule